// File: doc/BRIEF.md
# Colour Signature Template Matcher

This block holds a bank of learned colour-signature templates and scores a new test signature against every one of them. A signature is a histogram of 36 bins, each a 12-bit count. A learn request copies a signature into a chosen template slot and marks that slot as occupied. A match request latches a test signature. The block then walks the template store in banks of four slots. Four absolute-difference accumulators work side by side, one bin per cycle, so that each template ends with an 18-bit sum-of-absolute-differences error.

After each bank, the four errors go out one per cycle as an `{index, error}` pair with a valid strobe, in ascending slot order. A minimum tracker follows this stream and ignores slots that were never written. When the pass ends it holds the index and error of the closest template, and a match flag compares that error with a programmable threshold. The surrounding system learns a few reference objects first. It then presents signatures taken from image blocks and reads either the full error stream or only the winner.

Top module: `tm_matcher`

## Requirements
- R1: A learn request that is acknowledged (`learn_ack` high at a rising edge) writes all 36 bins of `learn_sig` into slot `learn_slot` and marks that slot occupied. Bin j occupies bits [12j+11:12j] of every signature port. Reset empties every slot and clears its contents to zero.
- R2: `learn_ack` equals `learn_req` whenever the matcher is idle and is low while `busy` is high. A request held through a match is therefore acknowledged in the cycle in which `done` is high.
- R3: `start` is accepted only while `busy` is low. `busy` rises in the next cycle and the test signature is latched at that edge. A `start` seen while busy has no effect.
- R4: The error for a template is the sum over all bins of |template bin − test bin|, carried in 18 bits without loss. An all-4095 template against an all-zero test gives 147420.
- R5: Each match pass emits exactly 32 results, one per slot, in ascending slot index. Occupied and empty slots are both emitted, and an empty slot scores as an all-zero template. Results within a bank arrive on consecutive cycles.
- R6: `done` is a one-cycle pulse in the first idle cycle. It arrives exactly 8 × (36 + 4) + 1 = 321 clock edges after the edge that accepted `start`.
- R7: `found`, `best_idx` and `best_err` report the smallest error over occupied slots only. With no occupied slot, `found` is 0.
- R8: When several occupied slots share the smallest error, `best_idx` is the lowest of their indices.
- R9: `match_found` is high exactly when `found` is 1 and `best_err` is strictly below `thresh`. It follows `thresh` without waiting for a new pass.
- R10: Between passes, `best_idx`, `best_err` and `found` hold their values and no result is emitted, until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| learn_req | input | 1 | Request to store `learn_sig` |
| learn_slot | input | 5 | Target slot for the learn request |
| learn_sig | input | 432 | Signature to store |
| learn_ack | output | 1 | Learn request accepted this cycle |
| start | input | 1 | Begin a match pass |
| test_sig | input | 432 | Signature to compare |
| busy | output | 1 | Match pass in progress |
| done | output | 1 | One-cycle end-of-pass pulse |
| res_valid | output | 1 | Result pair valid |
| res_idx | output | 5 | Slot index of the result |
| res_err | output | 18 | Error of that slot |
| thresh | input | 18 | Match threshold |
| found | output | 1 | At least one occupied slot was scored |
| best_idx | output | 5 | Slot with the smallest error |
| best_err | output | 18 | Smallest error |
| match_found | output | 1 | Smallest error is below threshold |

## Verification
The bench builds the block with its default parameters: 32 slots, 36 bins of 12 bits, and four engines. This makes the exact 321-edge pass length, the full 18-bit worst-case error of 147420, and the wrap from the last bank to the end pulse all observable. With the full-size store the bench can also place tied templates in different banks. It can hold a learn request across a whole pass and check that the write lands only after the end pulse.

// File: rtl/tm_pkg.sv
package tm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_EMIT,
        ST_FIN
    } tm_state_e;

    function automatic int pos_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/tm_store.sv
module tm_store #(
    parameter int N_SLOTS   = 32,
    parameter int N_BINS    = 36,
    parameter int BIN_W     = 12,
    parameter int N_ENG     = 4,
    parameter int SLOT_W    = 5,
    parameter int BIN_IDX_W = 6,
    parameter int BANK_W    = 3
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [SLOT_W-1:0]             wr_slot,
    input  logic [N_BINS*BIN_W-1:0]       wr_sig,
    input  logic [BANK_W-1:0]             rd_bank,
    input  logic [BIN_IDX_W-1:0]          rd_bin,
    output logic [N_ENG-1:0][BIN_W-1:0]   rd_data,
    output logic [N_SLOTS-1:0]            slot_valid
);

    logic [BIN_W-1:0] mem_q [N_SLOTS][N_BINS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < N_SLOTS; s++) begin
                for (int b = 0; b < N_BINS; b++) begin
                    mem_q[s][b] <= '0;
                end
            end
            slot_valid <= '0;
        end else if (wr_en) begin
            for (int b = 0; b < N_BINS; b++) begin
                mem_q[wr_slot][b] <= wr_sig[b*BIN_W +: BIN_W];
            end
            slot_valid[wr_slot] <= 1'b1;
        end
    end

    for (genvar e = 0; e < N_ENG; e++) begin : g_rd
        logic [SLOT_W-1:0] rd_slot;
        assign rd_slot    = SLOT_W'(rd_bank) * SLOT_W'(N_ENG) + SLOT_W'(e);
        assign rd_data[e] = mem_q[rd_slot][rd_bin];
    end

endmodule

// File: rtl/tm_sad_engine.sv
module tm_sad_engine #(
    parameter int BIN_W = 12,
    parameter int ERR_W = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             first,
    input  logic [BIN_W-1:0] tmpl_bin,
    input  logic [BIN_W-1:0] test_bin,
    output logic [ERR_W-1:0] acc
);

    logic [BIN_W-1:0] diff;

    always_comb begin
        if (tmpl_bin > test_bin) diff = tmpl_bin - test_bin;
        else                     diff = test_bin - tmpl_bin;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
        end else if (en) begin
            acc <= (first ? '0 : acc) + ERR_W'(diff);
        end
    end

endmodule

// File: rtl/tm_min_track.sv
module tm_min_track #(
    parameter int N_SLOTS = 32,
    parameter int SLOT_W  = 5,
    parameter int ERR_W   = 18
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic               in_valid,
    input  logic [SLOT_W-1:0]  in_idx,
    input  logic [ERR_W-1:0]   in_err,
    input  logic [N_SLOTS-1:0] slot_valid,
    output logic               found,
    output logic [SLOT_W-1:0]  best_idx,
    output logic [ERR_W-1:0]   best_err
);

    logic better;

    // strict compare: with ascending arrival the lower index keeps a tie
    assign better = in_valid && slot_valid[in_idx] && (!found || (in_err < best_err));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            found    <= 1'b0;
            best_idx <= '0;
            best_err <= '0;
        end else if (better) begin
            found    <= 1'b1;
            best_idx <= in_idx;
            best_err <= in_err;
        end
    end

endmodule

// File: rtl/tm_matcher.sv
module tm_matcher #(
    parameter int N_SLOTS = 32,
    parameter int N_BINS  = 36,
    parameter int BIN_W   = 12,
    parameter int N_ENG   = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          learn_req,
    input  logic [tm_pkg::pos_w(N_SLOTS)-1:0] learn_slot,
    input  logic [N_BINS*BIN_W-1:0]       learn_sig,
    output logic                          learn_ack,
    input  logic                          start,
    input  logic [N_BINS*BIN_W-1:0]       test_sig,
    output logic                          busy,
    output logic                          done,
    output logic                          res_valid,
    output logic [tm_pkg::pos_w(N_SLOTS)-1:0] res_idx,
    output logic [BIN_W+tm_pkg::pos_w(N_BINS)-1:0] res_err,
    input  logic [BIN_W+tm_pkg::pos_w(N_BINS)-1:0] thresh,
    output logic                          found,
    output logic [tm_pkg::pos_w(N_SLOTS)-1:0] best_idx,
    output logic [BIN_W+tm_pkg::pos_w(N_BINS)-1:0] best_err,
    output logic                          match_found
);
    import tm_pkg::*;

    localparam int SIG_W     = N_BINS * BIN_W;
    localparam int N_BANKS   = N_SLOTS / N_ENG;
    localparam int SLOT_W    = pos_w(N_SLOTS);
    localparam int BIN_IDX_W = pos_w(N_BINS);
    localparam int BANK_W    = pos_w(N_BANKS);
    localparam int ENG_W     = pos_w(N_ENG);
    localparam int ERR_W     = BIN_W + BIN_IDX_W;

    tm_state_e             state_q;
    logic [SIG_W-1:0]      test_q;
    logic [BANK_W-1:0]     bank_q;
    logic [BIN_IDX_W-1:0]  bin_q;
    logic [ENG_W-1:0]      emit_q;
    logic                  idle;
    logic                  take_start;
    logic [N_SLOTS-1:0]    slot_valid;
    logic [N_ENG-1:0][BIN_W-1:0] tmpl_bins;
    logic [N_ENG-1:0][ERR_W-1:0] acc;
    logic [BIN_W-1:0]      test_bin;
    logic [SLOT_W-1:0]     emit_slot;

    assign idle       = (state_q == ST_IDLE);
    assign busy       = !idle;
    assign take_start = idle && start;
    assign learn_ack  = idle && learn_req;
    assign test_bin   = test_q[bin_q*BIN_W +: BIN_W];
    assign emit_slot  = SLOT_W'(bank_q) * SLOT_W'(N_ENG) + SLOT_W'(emit_q);

    tm_store #(
        .N_SLOTS(N_SLOTS), .N_BINS(N_BINS), .BIN_W(BIN_W), .N_ENG(N_ENG),
        .SLOT_W(SLOT_W), .BIN_IDX_W(BIN_IDX_W), .BANK_W(BANK_W)
    ) u_store (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (learn_ack),
        .wr_slot    (learn_slot),
        .wr_sig     (learn_sig),
        .rd_bank    (bank_q),
        .rd_bin     (bin_q),
        .rd_data    (tmpl_bins),
        .slot_valid (slot_valid)
    );

    for (genvar e = 0; e < N_ENG; e++) begin : g_eng
        tm_sad_engine #(.BIN_W(BIN_W), .ERR_W(ERR_W)) u_eng (
            .clk      (clk),
            .rst      (rst),
            .en       (state_q == ST_RUN),
            .first    (bin_q == '0),
            .tmpl_bin (tmpl_bins[e]),
            .test_bin (test_bin),
            .acc      (acc[e])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            test_q    <= '0;
            bank_q    <= '0;
            bin_q     <= '0;
            emit_q    <= '0;
            done      <= 1'b0;
            res_valid <= 1'b0;
            res_idx   <= '0;
            res_err   <= '0;
        end else begin
            done      <= 1'b0;
            res_valid <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        test_q  <= test_sig;
                        bank_q  <= '0;
                        bin_q   <= '0;
                        state_q <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (bin_q == BIN_IDX_W'(N_BINS - 1)) begin
                        bin_q   <= '0;
                        emit_q  <= '0;
                        state_q <= ST_EMIT;
                    end else begin
                        bin_q <= bin_q + 1'b1;
                    end
                end
                ST_EMIT: begin
                    res_valid <= 1'b1;
                    res_idx   <= emit_slot;
                    res_err   <= acc[emit_q];
                    if (emit_q == ENG_W'(N_ENG - 1)) begin
                        if (bank_q == BANK_W'(N_BANKS - 1)) begin
                            state_q <= ST_FIN;
                        end else begin
                            bank_q  <= bank_q + 1'b1;
                            state_q <= ST_RUN;
                        end
                    end else begin
                        emit_q <= emit_q + 1'b1;
                    end
                end
                ST_FIN: begin
                    done    <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    tm_min_track #(.N_SLOTS(N_SLOTS), .SLOT_W(SLOT_W), .ERR_W(ERR_W)) u_min (
        .clk        (clk),
        .rst        (rst),
        .clear      (take_start),
        .in_valid   (res_valid),
        .in_idx     (res_idx),
        .in_err     (res_err),
        .slot_valid (slot_valid),
        .found      (found),
        .best_idx   (best_idx),
        .best_err   (best_err)
    );

    assign match_found = found && (best_err < thresh);

endmodule

// File: rtl/tm_matcher_chk.sv
module tm_matcher_chk #(
    parameter int SLOT_W = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              learn_ack,
    input logic              res_valid,
    input logic [SLOT_W-1:0] res_idx,
    input logic              found,
    input logic [SLOT_W-1:0] best_idx
);

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R2
    learn_hold_chk: assert property (@(posedge clk) disable iff (rst)
        learn_ack |-> !busy);

    // R3
    start_take_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R5
    res_busy_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> busy);

    // R5
    res_order_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && $past(res_valid)) |-> (res_idx == SLOT_W'($past(res_idx) + 1'b1)));

    // R10
    hold_best_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !$past(busy) && !$past(start)) |-> ($stable(best_idx) && $stable(found)));

endmodule

bind tm_matcher tm_matcher_chk #(.SLOT_W(SLOT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .learn_ack (learn_ack),
    .res_valid (res_valid),
    .res_idx   (res_idx),
    .found     (found),
    .best_idx  (best_idx)
);

// File: tb/tb_tm_matcher.sv
`timescale 1ns/1ps
module tb_tm_matcher;

    localparam int NS   = 32;
    localparam int NB   = 36;
    localparam int BW   = 12;
    localparam int NE   = 4;
    localparam int SW   = 5;
    localparam int EW   = 18;
    localparam int SIGW = NB * BW;
    localparam int PASS_EDGES = (NS / NE) * (NB + NE) + 1;

    logic            clk = 1'b0;
    logic            rst;
    logic            learn_req;
    logic [SW-1:0]   learn_slot;
    logic [SIGW-1:0] learn_sig;
    logic            learn_ack;
    logic            start;
    logic [SIGW-1:0] test_sig;
    logic            busy, done, res_valid, found, match_found;
    logic [SW-1:0]   res_idx, best_idx;
    logic [EW-1:0]   res_err, best_err, thresh;

    always #4 clk = ~clk;

    tm_matcher dut (
        .clk(clk), .rst(rst), .learn_req(learn_req), .learn_slot(learn_slot),
        .learn_sig(learn_sig), .learn_ack(learn_ack), .start(start),
        .test_sig(test_sig), .busy(busy), .done(done), .res_valid(res_valid),
        .res_idx(res_idx), .res_err(res_err), .thresh(thresh), .found(found),
        .best_idx(best_idx), .best_err(best_err), .match_found(match_found)
    );

    int n_chk = 0;
    int n_bad = 0;

    logic [SIGW-1:0] mdl [NS];
    bit              mval [NS];
    int              got_err [NS];
    int              rcount;
    int              rnext;
    int              rorder_bad;
    int              pass_edges;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [SIGW-1:0] mk_sig(input int seed);
        logic [SIGW-1:0] s;
        for (int j = 0; j < NB; j++) s[j*BW +: BW] = BW'((seed * 53 + j * 97 + seed * j * 7) % 4096);
        return s;
    endfunction

    function automatic int sad(input logic [SIGW-1:0] a, input logic [SIGW-1:0] b);
        int t = 0;
        for (int j = 0; j < NB; j++) begin
            int x = int'(a[j*BW +: BW]);
            int y = int'(b[j*BW +: BW]);
            t += (x > y) ? x - y : y - x;
        end
        return t;
    endfunction

    always @(negedge clk) begin
        if (res_valid) begin
            got_err[res_idx] = int'(res_err);
            if (int'(res_idx) != rnext) rorder_bad++;
            rnext++;
            rcount++;
        end
    end

    task automatic do_learn(input int slot, input logic [SIGW-1:0] sig, input bit expect_done);
        int waited = 0;
        @(negedge clk);
        learn_req  = 1'b1;
        learn_slot = SW'(slot);
        learn_sig  = sig;
        forever begin
            #1;
            if (learn_ack && busy)
                chk(1'b0, "R2", "ack while busy", 1, 0);
            if (learn_ack) break;
            @(negedge clk);
            waited++;
        end
        if (expect_done)
            chk(done == 1'b1, "R2", "held learn acked with done", int'(done), 1);
        @(posedge clk);
        @(negedge clk);
        learn_req = 1'b0;
        mdl[slot]  = sig;
        mval[slot] = 1'b1;
    endtask

    task automatic do_match(input logic [SIGW-1:0] sig, input int poke_at);
        rcount = 0; rnext = 0; rorder_bad = 0;
        @(negedge clk);
        start    = 1'b1;
        test_sig = sig;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        test_sig = ~sig;
        pass_edges = 0;
        do begin
            @(posedge clk);
            pass_edges++;
            @(negedge clk);
            if (pass_edges == poke_at) start = 1'b1;
            else start = 1'b0;
        end while (!done && pass_edges < 2000);
        start = 1'b0;
    endtask

    task automatic check_pass(input logic [SIGW-1:0] sig, input string tag);
        int bi = -1;
        int be = 0;
        chk(pass_edges == PASS_EDGES, "R6", {tag, " pass length"}, pass_edges, PASS_EDGES);
        chk(rcount == NS, "R5", {tag, " result count"}, rcount, NS);
        chk(rorder_bad == 0, "R5", {tag, " result order"}, rorder_bad, 0);
        for (int s = 0; s < NS; s++) begin
            int e = mval[s] ? sad(mdl[s], sig) : sad('0, sig);
            chk(got_err[s] == e, "R4", {tag, " slot error"}, got_err[s], e);
            if (mval[s] && (bi < 0 || e < be)) begin bi = s; be = e; end
        end
        chk(found == (bi >= 0), "R7", {tag, " found"}, int'(found), int'(bi >= 0));
        if (bi >= 0) begin
            chk(int'(best_idx) == bi, "R7", {tag, " best index"}, best_idx, bi);
            chk(int'(best_err) == be, "R7", {tag, " best error"}, best_err, be);
        end
    endtask

    task automatic t_reset();
        chk(busy == 1'b0, "R3", "busy after reset", busy, 0);
        chk(done == 1'b0, "R6", "done after reset", done, 0);
        chk(found == 1'b0, "R7", "found after reset", found, 0);
        chk(res_valid == 1'b0, "R5", "res_valid after reset", res_valid, 0);
    endtask

    task automatic t_empty();
        logic [SIGW-1:0] s = mk_sig(3);
        thresh = '1;
        do_match(s, 0);
        check_pass(s, "empty");
        chk(match_found == 1'b0, "R9", "no match when empty", match_found, 0);
    endtask

    task automatic t_learn_exact();
        do_learn(5, mk_sig(11), 1'b0);
        do_learn(9, mk_sig(22), 1'b0);
        do_learn(20, mk_sig(33), 1'b0);
        do_match(mk_sig(22), 0);
        check_pass(mk_sig(22), "exact");
        chk(best_idx == SW'(9) && best_err == '0, "R1", "stored slot 9 matches exactly", best_idx, 9);
    endtask

    task automatic t_tie();
        logic [SIGW-1:0] a = mk_sig(44);
        logic [SIGW-1:0] t;
        do_learn(12, a, 1'b0);
        do_learn(3, a, 1'b0);
        t = a;
        t[BW-1:0] = t[BW-1:0] ^ 12'h001;
        do_match(t, 0);
        check_pass(t, "tie");
        chk(int'(best_idx) == 3, "R8", "tie goes to lower slot", best_idx, 3);
        chk(int'(best_err) == 1, "R8", "tie error", best_err, 1);
    endtask

    task automatic t_threshold();
        thresh = best_err;
        #1;
        chk(match_found == 1'b0, "R9", "error equal to threshold", match_found, 0);
        thresh = best_err + 1'b1;
        #1;
        chk(match_found == 1'b1, "R9", "error below threshold", match_found, 1);
    endtask

    task automatic t_hold();
        logic [SW-1:0] bi0 = best_idx;
        logic [EW-1:0] be0 = best_err;
        int rc0 = rcount;
        repeat (20) @(negedge clk);
        chk(best_idx == bi0 && best_err == be0, "R10", "best held between passes", best_err, be0);
        chk(rcount == rc0, "R10", "no results between passes", rcount, rc0);
    endtask

    task automatic t_start_ignored();
        logic [SIGW-1:0] s = mk_sig(5);
        do_match(s, 50);
        check_pass(s, "start while busy");
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R3", "no second pass from busy start", busy, 0);
    endtask

    task automatic t_learn_busy();
        logic [SIGW-1:0] s = mk_sig(7);
        fork
            do_match(s, 0);
            begin
                repeat (10) @(negedge clk);
                do_learn(30, mk_sig(66), 1'b1);
            end
        join
        mval[30] = 1'b0;
        check_pass(s, "learn during pass");
        mval[30] = 1'b1;
        do_match(mk_sig(66), 0);
        check_pass(mk_sig(66), "after held learn");
        chk(int'(best_idx) == 30 && best_err == '0, "R2", "held learn landed", best_idx, 30);
    endtask

    task automatic t_max_err();
        logic [SIGW-1:0] z = '0;
        do_learn(31, '1, 1'b0);
        do_match(z, 0);
        check_pass(z, "max");
        chk(got_err[31] == 147420, "R4", "worst-case error", got_err[31], 147420);
    endtask

    initial begin
        #(200000 * 8);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int s = 0; s < NS; s++) begin mval[s] = 1'b0; mdl[s] = '0; got_err[s] = -1; end
        rcount = 0; rnext = 0; rorder_bad = 0;
        rst = 1'b1; learn_req = 1'b0; learn_slot = '0; learn_sig = '0;
        start = 1'b0; test_sig = '0; thresh = EW'(155);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_empty();
        t_learn_exact();
        t_tie();
        t_threshold();
        t_hold();
        t_start_ignored();
        t_learn_busy();
        t_max_err();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule